// File: doc/BRIEF.md
# Adaptive Two-Bit Age Replacement Engine

This block decides which way of a set-associative cache to evict. It holds a two-bit age for every line of every set. Cache accesses refresh or insert those ages. A victim request for a set returns the way to replace. The tag array, the data array and the miss machinery sit outside the block. They report each lookup as an access on the access port and ask for a victim on the victim port.

Two insertion flavours exist, and they differ only in the age a demand fill receives. Flavour A places a demand fill at age 1. Flavour B places it at age 3, where it becomes the next eviction candidate, which protects the set against streaming data. A prefetch fill lands at age 2 in both flavours.

A few sets are hard-wired to each flavour. Misses in those sets move a saturating selector up or down, and the selector's top bit chooses the flavour that every other set uses.

Top module: `age_repl_ctrl`

## Requirements
- R1: After reset every line has age 3, `vic_valid` is 0, and the selector holds 2^(PSEL_W-1)-1, so follower sets start in flavour A. A victim request to any untouched set returns way 0.
- R2: An access with `acc_hit`=1 sets the age of line (`acc_set`, `acc_way`) to 0.
- R3: An access with `acc_hit`=0 and `acc_pref`=1 is a prefetch fill and sets that line's age to 2 in either flavour.
- R4: A demand fill (`acc_hit`=0, `acc_pref`=0) in a set using flavour A sets the line's age to 1.
- R5: A demand fill in a set using flavour B sets the line's age to 3.
- R6: Set roles come from the DUEL_BITS low bits of the set index. All zeros marks a flavour-A dedicated set. All ones marks a flavour-B dedicated set. Any other value marks a follower set.
- R7: Every miss (`acc_hit`=0) in a flavour-A dedicated set raises the PSEL_W-bit selector by 1, saturating at 2^PSEL_W-1. Every miss in a flavour-B dedicated set lowers it by 1, saturating at 0. Hits leave it unchanged.
- R8: Follower sets use flavour B while the selector's most significant bit is 1 and flavour A while it is 0.
- R9: A victim request adds (3 - oldest age in the set) to every age of that set, and the raised ages are kept.
- R10: The returned victim is the lowest-numbered way whose age, after the raise in R9, equals 3.
- R11: `vic_valid` is 1 in exactly the cycle after a cycle with `vic_req`=1, and `vic_way` is valid in that cycle.
- R12: When an access and a victim request target the same set in one cycle, the victim is chosen from the ages stored before that cycle. The accessed line takes the age the access gives it, and the other lines of the set take the raised ages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event present this cycle |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_way | input | $clog2(WAYS) | Way hit, or way being filled on a miss |
| acc_hit | input | 1 | 1 = hit, 0 = miss with fill into `acc_way` |
| acc_pref | input | 1 | 1 = the access is a prefetch |
| vic_req | input | 1 | Victim request this cycle |
| vic_set | input | $clog2(SETS) | Set for which a victim is wanted |
| vic_valid | output | 1 | Victim result strobe |
| vic_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
An age or selector change caused by an access takes effect at the clock edge that samples the access. It becomes visible only through the answer to a later victim request. The victim answer itself is registered, so `vic_valid` and `vic_way` are due one edge after the request.

The bench drives each stimulus at the falling edge and keeps a reference model of ages and selector, updated in the same order that R12 fixes. It compares the outputs a short delay after the next rising edge. Directed sequences pick set indices and access patterns whose expected victim differs between the two flavours, with and without saturation, and with and without kept ages.

// File: rtl/age_repl_pkg.sv
package age_repl_pkg;

    typedef enum logic [1:0] {
        ROLE_FOLLOW = 2'd0,
        ROLE_LEAD_A = 2'd1,
        ROLE_LEAD_B = 2'd2
    } set_role_e;

    typedef enum logic {
        FLAV_A = 1'b0,
        FLAV_B = 1'b1
    } flavour_e;

    localparam logic [1:0] AGE_NEWEST   = 2'd0;
    localparam logic [1:0] AGE_DEMAND_A = 2'd1;
    localparam logic [1:0] AGE_PREFETCH = 2'd2;
    localparam logic [1:0] AGE_OLDEST   = 2'd3;

endpackage

// File: rtl/age_set_role.sv
module age_set_role
    import age_repl_pkg::*;
#(
    parameter int SET_W     = 6,
    parameter int DUEL_BITS = 4
) (
    input  logic [SET_W-1:0] set_idx,
    output set_role_e        role
);
    localparam logic [DUEL_BITS-1:0] TAG_A = '0;
    localparam logic [DUEL_BITS-1:0] TAG_B = '1;

    logic [DUEL_BITS-1:0] low_bits;
    assign low_bits = set_idx[DUEL_BITS-1:0];

    always_comb begin
        if (low_bits == TAG_A)      role = ROLE_LEAD_A;
        else if (low_bits == TAG_B) role = ROLE_LEAD_B;
        else                        role = ROLE_FOLLOW;
    end
endmodule

// File: rtl/age_duel_psel.sv
module age_duel_psel #(
    parameter int PSEL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_a,
    input  logic              miss_b,
    output logic              pick_b,
    output logic [PSEL_W-1:0] psel
);
    localparam logic [PSEL_W-1:0] PSEL_INIT = {1'b0, {(PSEL_W-1){1'b1}}};
    localparam logic [PSEL_W-1:0] PSEL_MAX  = '1;
    localparam logic [PSEL_W-1:0] PSEL_MIN  = '0;

    typedef struct packed {
        logic [PSEL_W-1:0] cnt;
    } psel_st_t;

    psel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (miss_a && !miss_b && st_q.cnt != PSEL_MAX)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (miss_b && !miss_a && st_q.cnt != PSEL_MIN)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: PSEL_INIT};
        else        st_q <= st_d;
    end

    assign psel   = st_q.cnt;
    assign pick_b = st_q.cnt[PSEL_W-1];
endmodule

// File: rtl/age_victim_pick.sv
module age_victim_pick
    import age_repl_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][1:0] ages_in,
    output logic [WAYS-1:0][1:0] ages_raised,
    output logic [WAY_W-1:0]     victim
);
    logic [1:0] oldest;
    logic [1:0] bump;
    logic       found;

    always_comb begin
        oldest = AGE_NEWEST;
        for (int w = 0; w < WAYS; w++) begin
            if (ages_in[w] > oldest) oldest = ages_in[w];
        end
        bump = AGE_OLDEST - oldest;
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_raise
        assign ages_raised[g] = ages_in[g] + bump;
    end

    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && ages_raised[w] == AGE_OLDEST) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/age_repl_ctrl.sv
module age_repl_ctrl
    import age_repl_pkg::*;
#(
    parameter int SETS      = 64,
    parameter int WAYS      = 4,
    parameter int DUEL_BITS = 4,
    parameter int PSEL_W    = 10,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             acc_hit,
    input  logic             acc_pref,
    input  logic             vic_req,
    input  logic [SET_W-1:0] vic_set,
    output logic             vic_valid,
    output logic [WAY_W-1:0] vic_way
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][1:0] age;
        logic                           vic_valid;
        logic [WAY_W-1:0]               vic_way;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    set_role_e           acc_role;
    flavour_e            acc_flav;
    logic                pick_b;
    logic [PSEL_W-1:0]   psel_val;
    logic                miss_a;
    logic                miss_b;
    logic [1:0]          fill_age;
    logic [WAYS-1:0][1:0] vic_row;
    logic [WAYS-1:0][1:0] vic_row_raised;
    logic [WAY_W-1:0]    pick_way;

    age_set_role #(
        .SET_W     (SET_W),
        .DUEL_BITS (DUEL_BITS)
    ) role_i (
        .set_idx (acc_set),
        .role    (acc_role)
    );

    assign miss_a = acc_valid && !acc_hit && (acc_role == ROLE_LEAD_A);
    assign miss_b = acc_valid && !acc_hit && (acc_role == ROLE_LEAD_B);

    age_duel_psel #(
        .PSEL_W (PSEL_W)
    ) psel_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .miss_a (miss_a),
        .miss_b (miss_b),
        .pick_b (pick_b),
        .psel   (psel_val)
    );

    always_comb begin
        unique case (acc_role)
            ROLE_LEAD_A: acc_flav = FLAV_A;
            ROLE_LEAD_B: acc_flav = FLAV_B;
            default:     acc_flav = pick_b ? FLAV_B : FLAV_A;
        endcase
    end

    always_comb begin
        if (acc_pref)                fill_age = AGE_PREFETCH;
        else if (acc_flav == FLAV_B) fill_age = AGE_OLDEST;
        else                         fill_age = AGE_DEMAND_A;
    end

    assign vic_row = st_q.age[vic_set];

    age_victim_pick #(
        .WAYS (WAYS)
    ) pick_i (
        .ages_in     (vic_row),
        .ages_raised (vic_row_raised),
        .victim      (pick_way)
    );

    always_comb begin
        st_d           = st_q;
        st_d.vic_valid = vic_req;
        if (vic_req) begin
            st_d.age[vic_set] = vic_row_raised;
            st_d.vic_way      = pick_way;
        end
        if (acc_valid) begin
            st_d.age[acc_set][acc_way] = acc_hit ? AGE_NEWEST : fill_age;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.age       <= '1;
            st_q.vic_valid <= 1'b0;
            st_q.vic_way   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vic_valid = st_q.vic_valid;
    assign vic_way   = st_q.vic_way;
endmodule

// File: rtl/age_repl_chk.sv
module age_repl_chk #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int PSEL_W = 10,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           acc_valid,
    input logic [SET_W-1:0]               acc_set,
    input logic [WAY_W-1:0]               acc_way,
    input logic                           acc_hit,
    input logic                           vic_req,
    input logic [SET_W-1:0]               vic_set,
    input logic                           vic_valid,
    input logic [WAY_W-1:0]               vic_way,
    input logic [SETS-1:0][WAYS-1:0][1:0] ages,
    input logic [PSEL_W-1:0]              psel
);
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_valid); // R11

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_valid); // R11

    AST_HIT_ZEROES_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=> ages[$past(acc_set)][$past(acc_way)] == 2'd0); // R2

    AST_SEL_HOLD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_hit) |=> $stable(psel)); // R7

    AST_SEL_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (psel == $past(psel)) || (psel == $past(psel) + 1'b1)
                      || (psel == $past(psel) - 1'b1)); // R7

    AST_VICTIM_IS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && !$past(acc_valid && (acc_set == vic_set)))
        |-> ages[$past(vic_set)][vic_way] == 2'd3); // R10
endmodule

bind age_repl_ctrl age_repl_chk #(
    .SETS   (SETS),
    .WAYS   (WAYS),
    .PSEL_W (PSEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .acc_hit   (acc_hit),
    .vic_req   (vic_req),
    .vic_set   (vic_set),
    .vic_valid (vic_valid),
    .vic_way   (vic_way),
    .ages      (st_q.age),
    .psel      (psel_val)
);

// File: tb/age_repl_ctrl_tb_top.sv
`timescale 1ns/1ps
module age_repl_ctrl_tb_top;
    localparam int SETS      = 64;
    localparam int WAYS      = 4;
    localparam int DUEL_BITS = 4;
    localparam int PSEL_W    = 10;
    localparam int SET_W     = $clog2(SETS);
    localparam int WAY_W     = $clog2(WAYS);
    localparam int PSEL_MAX  = (1 << PSEL_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [SET_W-1:0] acc_set = '0;
    logic [WAY_W-1:0] acc_way = '0;
    logic             acc_hit = 1'b0;
    logic             acc_pref = 1'b0;
    logic             vic_req = 1'b0;
    logic [SET_W-1:0] vic_set = '0;
    logic             vic_valid;
    logic [WAY_W-1:0] vic_way;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_age [SETS][WAYS];
    int m_psel;

    always #2.5 clk = ~clk;

    age_repl_ctrl #(
        .SETS (SETS), .WAYS (WAYS), .DUEL_BITS (DUEL_BITS), .PSEL_W (PSEL_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .acc_valid (acc_valid), .acc_set (acc_set), .acc_way (acc_way),
        .acc_hit (acc_hit), .acc_pref (acc_pref),
        .vic_req (vic_req), .vic_set (vic_set),
        .vic_valid (vic_valid), .vic_way (vic_way)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int role_of(input int s);
        int low = s & ((1 << DUEL_BITS) - 1);
        if (low == 0) return 1;
        if (low == (1 << DUEL_BITS) - 1) return 2;
        return 0;
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_age[s][w] = 3;
        m_psel = (1 << (PSEL_W - 1)) - 1;
    endfunction

    function automatic int model_victim(input int s);
        int mx = 0;
        int v = -1;
        for (int w = 0; w < WAYS; w++) if (m_age[s][w] > mx) mx = m_age[s][w];
        for (int w = 0; w < WAYS; w++) begin
            m_age[s][w] += 3 - mx;
            if (v < 0 && m_age[s][w] == 3) v = w;
        end
        return v;
    endfunction

    function automatic void model_access(input int s, input int w, input bit hit, input bit pref);
        int r = role_of(s);
        bit use_b = (r == 2) || (r == 0 && m_psel >= (1 << (PSEL_W - 1)));
        if (hit) m_age[s][w] = 0;
        else if (pref) m_age[s][w] = 2;
        else m_age[s][w] = use_b ? 3 : 1;
        if (!hit && r == 1 && m_psel < PSEL_MAX) m_psel++;
        if (!hit && r == 2 && m_psel > 0) m_psel--;
    endfunction

    // One clock of stimulus; victim result checked after the next rising edge.
    task automatic cyc(input string tag, input bit av, input int as, input int aw,
                       input bit ah, input bit ap, input bit vr, input int vs);
        int exp_way = 0;
        @(negedge clk);
        acc_valid = av; acc_set = SET_W'(as); acc_way = WAY_W'(aw);
        acc_hit = ah; acc_pref = ap; vic_req = vr; vic_set = SET_W'(vs);
        if (vr) exp_way = model_victim(vs);
        if (av) model_access(as, aw, ah, ap);
        @(posedge clk);
        #1;
        chk(tag, int'(vic_valid), int'(vr));
        if (vr) chk(tag, int'(vic_way), exp_way);
    endtask

    task automatic acc(input string tag, input int s, input int w, input bit h, input bit p);
        cyc(tag, 1'b1, s, w, h, p, 1'b0, 0);
    endtask

    task automatic vic(input string tag, input int s);
        cyc(tag, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1, s);
    endtask

    // demand fill w0, prefetch fill w1, hit w2/w3: victim w0 under B, w1 under A
    task automatic flav_probe(input string tag, input int s);
        acc(tag, s, 0, 1'b0, 1'b0);
        acc(tag, s, 1, 1'b0, 1'b1);
        acc(tag, s, 2, 1'b1, 1'b0);
        acc(tag, s, 3, 1'b1, 1'b0);
        vic(tag, s);
    endtask

    initial begin
        #500000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        #1 chk("R1 valid low in reset", int'(vic_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 chk("R1 valid low after reset", int'(vic_valid), 0);

        vic("R1 fresh set gives way0", 5);

        // R2: hits refresh to age 0
        for (int w = 0; w < 3; w++) acc("R2", 5, w, 1'b1, 1'b0);
        vic("R2 unhit way chosen", 5);
        for (int w = 0; w < 4; w++) acc("R2", 5, w, 1'b1, 1'b0);
        vic("R2 all hit", 5);

        // R3: prefetch fill at age 2
        acc("R3", 6, 2, 1'b0, 1'b1);
        acc("R3", 6, 0, 1'b1, 1'b0);
        acc("R3", 6, 1, 1'b1, 1'b0);
        acc("R3", 6, 3, 1'b1, 1'b0);
        vic("R3 prefetch line oldest", 6);

        flav_probe("R8 follower flavour A at reset", 7);
        // R4: set 0 is flavour-A dedicated; demand w1=1, prefetch w2=2
        acc("R4", 0, 1, 1'b0, 1'b0);
        acc("R4", 0, 2, 1'b0, 1'b1);
        acc("R4", 0, 0, 1'b1, 1'b0);
        acc("R4", 0, 3, 1'b1, 1'b0);
        vic("R4 demand below prefetch", 0);
        flav_probe("R8 follower flavour B after A misses", 9);
        // R5: set 15 is flavour-B dedicated
        acc("R5", 15, 2, 1'b0, 1'b0);
        acc("R5", 15, 3, 1'b0, 1'b1);
        acc("R5", 15, 0, 1'b1, 1'b0);
        acc("R5", 15, 1, 1'b1, 1'b0);
        vic("R5 demand at oldest", 15);

        flav_probe("R6 set31 dedicated B", 31);
        flav_probe("R6 set48 dedicated A", 48);
        flav_probe("R6 set17 follower", 17);

        // R7: saturate low, step up, then saturate high, step down
        for (int i = 0; i < 600; i++) acc("R7", 47, i % 4, 1'b0, 1'b0);
        acc("R7", 32, 0, 1'b0, 1'b0);
        flav_probe("R7 low saturation", 10);
        for (int i = 0; i < 1100; i++) acc("R7", 16, i % 4, 1'b0, 1'b1);
        acc("R7", 63, 0, 1'b0, 1'b0);
        flav_probe("R7 high saturation", 11);

        // R9: raised ages kept
        for (int w = 0; w < 4; w++) acc("R9", 12, w, 1'b1, 1'b0);
        acc("R9", 12, 2, 1'b0, 1'b1);
        vic("R9", 12);
        acc("R9", 12, 2, 1'b1, 1'b0);
        acc("R9", 12, 3, 1'b0, 1'b1);
        vic("R9", 12);
        acc("R9", 12, 3, 1'b1, 1'b0);
        acc("R9", 12, 0, 1'b1, 1'b0);
        vic("R9 kept ages pick way1", 12);

        // R12: same-set access and victim in one cycle
        for (int w = 0; w < 4; w++) acc("R12", 13, w, 1'b1, 1'b0);
        acc("R12", 13, 1, 1'b0, 1'b1);
        cyc("R12 victim from stored ages", 1'b1, 13, 1, 1'b1, 1'b0, 1'b1, 13);
        vic("R12 access wins on its line", 13);

        // R11: strobe only one cycle
        vic("R11", 20);
        cyc("R11 strobe drops", 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0);

        // random traffic, every victim compared with the model (R10)
        for (int i = 0; i < 5000; i++) begin
            bit av = ($urandom % 4) != 0;
            bit vr = ($urandom % 3) == 0;
            int as = $urandom % SETS;
            int vs = (($urandom % 4) == 0) ? as : int'($urandom % SETS);
            cyc("R10 random", av, as, $urandom % WAYS, ($urandom % 2) == 1,
                ($urandom % 3) == 0, vr, vs);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule